// File: doc/BRIEF.md
# Key-Locked GPIO Pad Controller

This block is a register-mapped controller for a parameterizable bank of general-purpose pins. Software reaches it over a simple word-addressed register bus with an address, write data, a write strobe, a read strobe and registered read data. Each pin has a configuration byte and a configuration nibble. The byte holds pull-up, input enable, drive strength and a 3-bit function select. The nibble holds a 2-bit output mode and an interrupt edge direction. Both sets of configuration can only be changed while an unlock key is held.

When a pin's function select is 3 (plain GPIO), its output comes from a data register and, in tri-state mode, from an output-enable register. Both registers can be written three ways: a plain write, a write-one-to-set alias and a write-one-to-clear alias. Pin inputs pass through a two-flop synchronizer. They are masked to 0 unless input enable is set. A sticky status bit then records a rising or falling edge on each pin, and the interrupt line is the OR of the status bits whose enable bit is set.

The bus has no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled high. Read data is captured at the edge where `bus_rd` is sampled high and holds until the next read. The pad-side signals are plain levels with no handshake.

Top module: `keyed_gpio`

Register map (word addresses; word `w` of a bank sits at base + w):

| Base | Access | Contents |
|------|--------|----------|
| 0x00 | R/W | key: writing 0x73 unlocks and any other value locks; bit 0 reads 1 while unlocked |
| 0x10 | R/W, key-locked | pad bytes, four pins per word, pin p in byte p%4 |
| 0x20 | R/W, key-locked | aux nibbles, eight pins per word, pin p in nibble p%8 |
| 0x30 | R | masked synchronized pin inputs, 32 pins per word |
| 0x34 / 0x38 / 0x3C | R/W / W1S / W1C | output data |
| 0x40 / 0x44 / 0x48 | R/W / W1S / W1C | output enable |
| 0x50 | R/W | interrupt enable |
| 0x54 | R/W1C | interrupt status |

## Requirements
- R1: Writing 0x73 to address 0x00 unlocks the configuration registers and writing any other value locks them. Bit 0 of address 0x00 reads 1 while unlocked and 0 while locked.
- R2: While locked, writes to the pad-byte words (0x10+) and aux-nibble words (0x20+) leave every stored configuration bit unchanged.
- R3: Each pad byte has the following fields: bit 0 pull-up, bit 1 input enable, bit 2 drive strength, bits 5:3 function select. Bits 7:6 read 0. The outputs `pad_pull`, `pad_strong` and `pad_func` (3 bits per pin, pin p at [3p+2:3p]) reflect the stored fields.
- R4: Each aux nibble has the following fields: bits 1:0 output mode and bit 2 edge direction (0 rising, 1 falling). Bit 3 reads 0, and nibbles of pins beyond N read 0.
- R5: A pin whose function select is not 3 has `pad_oe` and `pad_out` both 0, whatever its data, enable and mode.
- R6: With function 3, the output mode sets the pin as follows. Mode 0 (off): oe=0, out=0. Mode 1 (push-pull): oe=1, out=data. Mode 2 (open-drain): oe=NOT data, out=0. Mode 3 (tri-state): oe=enable bit, out=data.
- R7: The output data register takes a plain write at 0x34+w. Writing 1 bits to 0x38+w sets those bits and writing 1 bits to 0x3C+w clears them, with all other bits unchanged. Bits beyond N read 0.
- R8: The output enable register has the same plain/set/clear behaviour at 0x40+w, 0x44+w and 0x48+w.
- R9: Address 0x30+w returns the synchronized pin inputs ANDed with the input enables. Pins 0-31 are in word 0 and higher pins in word 1. Bits beyond N read 0.
- R10: A rising edge (direction 0) or falling edge (direction 1) on the masked synchronized input sets a sticky status bit. Writing 1 to that bit at 0x54+w clears it. An edge in the same cycle as the clear wins.
- R11: `irq` is 1 exactly when some status bit and the matching interrupt-enable bit (0x50+w) are both 1.
- R12: After reset the controller is locked, all configuration, data, enable, interrupt-enable and status bits are 0, and `pad_oe`, `pad_out` and `irq` are 0.
- R13: `bus_rdata` shows the addressed word from the cycle after `bus_rd` is sampled high, and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | 8 | word address |
| bus_wdata | input | 32 | write data |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_rdata | output | 32 | registered read data |
| pad_in | input | N | raw pin inputs |
| pad_out | output | N | pin output level |
| pad_oe | output | N | pin output enable |
| pad_pull | output | N | pull-up enable per pin |
| pad_strong | output | N | high drive strength per pin |
| pad_func | output | 3*N | function select per pin |
| irq | output | 1 | combined edge interrupt |

## Verification
The bench builds the block with N = 36. With that size the pad-byte words are exactly full, the last aux word is half full, and the second input, data, enable and interrupt words carry only four live bits, so the masking of bits beyond N comes into reach. Every output mode is swept over all 36 pins at once with several data and enable patterns. The stored-field readback is swept over all 256 byte values, and the edge tests mix rising-detecting even pins with falling-detecting odd pins in both words.

// File: rtl/gpk_pkg.sv
package gpk_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_0073;
  localparam logic [2:0]  FN_GPIO    = 3'd3;

  localparam logic [7:0] A_KEY  = 8'h00;
  localparam logic [7:0] A_PAD  = 8'h10;
  localparam logic [7:0] A_AUX  = 8'h20;
  localparam logic [7:0] A_IN   = 8'h30;
  localparam logic [7:0] A_DAT  = 8'h34;
  localparam logic [7:0] A_DSET = 8'h38;
  localparam logic [7:0] A_DCLR = 8'h3C;
  localparam logic [7:0] A_OEN  = 8'h40;
  localparam logic [7:0] A_OSET = 8'h44;
  localparam logic [7:0] A_OCLR = 8'h48;
  localparam logic [7:0] A_IEN  = 8'h50;
  localparam logic [7:0] A_IST  = 8'h54;

  typedef enum logic [1:0] {
    OM_OFF   = 2'd0,
    OM_PUSH  = 2'd1,
    OM_DRAIN = 2'd2,
    OM_TRI   = 2'd3
  } out_mode_e;

  // byte layout: [5:3] func, [2] drive, [1] input enable, [0] pull-up
  typedef struct packed {
    logic [2:0] func;
    logic       drive;
    logic       inen;
    logic       pull;
  } pad_cfg_t;

  // nibble layout: [2] falling-edge select, [1:0] output mode
  typedef struct packed {
    logic      fall;
    out_mode_e mode;
  } aux_cfg_t;
endpackage

// File: rtl/gpk_cfg_bank.sv
module gpk_cfg_bank import gpk_pkg::*; #(
  parameter int N = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        wr,
  output pad_cfg_t    pcfg [N],
  output aux_cfg_t    xcfg [N],
  output logic [31:0] rdata
);
  logic unlk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) unlk_q <= 1'b0;
    else if (wr && addr == A_KEY) unlk_q <= (wdata == UNLOCK_KEY);
  end

  for (genvar p = 0; p < N; p++) begin : g_pin
    localparam logic [7:0] PA = A_PAD + 8'(p / 4);
    localparam logic [7:0] XA = A_AUX + 8'(p / 8);
    localparam int PB = (p % 4) * 8;
    localparam int XB = (p % 8) * 4;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pcfg[p] <= '0;
        xcfg[p] <= '0;
      end else if (unlk_q && wr) begin
        if (addr == PA) pcfg[p] <= pad_cfg_t'(wdata[PB +: 6]);
        if (addr == XA) xcfg[p] <= aux_cfg_t'(wdata[XB +: 3]);
      end
    end

    // R2: without an unlocked write the stored configuration cannot move
    a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(unlk_q && wr) |=> ($stable(pcfg[p]) && $stable(xcfg[p])));
  end

  always_comb begin
    rdata = '0;
    if (addr == A_KEY) rdata[0] = unlk_q;
    for (int p = 0; p < N; p++) begin
      if (addr == A_PAD + 8'(p / 4)) rdata[(p % 4) * 8 +: 6] = pcfg[p];
      if (addr == A_AUX + 8'(p / 8)) rdata[(p % 8) * 4 +: 3] = xcfg[p];
    end
  end

  a_r1_key_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_KEY) |=> (unlk_q == ($past(wdata) == UNLOCK_KEY)));
endmodule

// File: rtl/gpk_setclr_reg.sv
module gpk_setclr_reg #(
  parameter int         N      = 40,
  parameter logic [7:0] A_BASE = 8'h34,
  parameter logic [7:0] A_SET  = 8'h38,
  parameter logic [7:0] A_CLR  = 8'h3C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   addr,
  input  logic [31:0]  wdata,
  input  logic         wr,
  output logic [N-1:0] q,
  output logic [31:0]  rdata
);
  localparam int NW = (N + 31) / 32;

  logic [31:0] rdw [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int LO = w * 32;
    localparam int WB = ((N - LO) < 32) ? (N - LO) : 32;
    localparam logic [7:0] AB = A_BASE + 8'(w);
    localparam logic [7:0] AS = A_SET + 8'(w);
    localparam logic [7:0] AC = A_CLR + 8'(w);

    always_ff @(posedge clk) begin
      if (!rst_n)                q[LO +: WB] <= '0;
      else if (wr && addr == AB) q[LO +: WB] <= wdata[WB-1:0];
      else if (wr && addr == AS) q[LO +: WB] <= q[LO +: WB] | wdata[WB-1:0];
      else if (wr && addr == AC) q[LO +: WB] <= q[LO +: WB] & ~wdata[WB-1:0];
    end

    assign rdw[w] = (addr == AB) ? 32'(q[LO +: WB]) : 32'h0;

    // R7 (and R8 for the enable instance): set alias forces ones, clear alias forces zeros
    a_r7_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AS) |=> ((q[LO +: WB] & $past(wdata[WB-1:0])) == $past(wdata[WB-1:0])));
    a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AC) |=> ((q[LO +: WB] & $past(wdata[WB-1:0])) == '0));
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NW; w++) rdata = rdata | rdw[w];
  end
endmodule

// File: rtl/gpk_in_sense.sv
module gpk_in_sense import gpk_pkg::*; #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   addr,
  input  logic [31:0]  wdata,
  input  logic         wr,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] inen,
  input  logic [N-1:0] fall,
  output logic [31:0]  rdata,
  output logic         irq
);
  localparam int NW = (N + 31) / 32;

  logic [N-1:0] s1_q, s2_q, prev_q, ien_q, ist_q;
  logic [N-1:0] seen, hit;
  logic [31:0]  rdw [NW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= seen;
    end
  end

  assign seen = s2_q & inen;
  assign hit  = (seen & ~prev_q & ~fall) | (~seen & prev_q & fall);

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int LO = w * 32;
    localparam int WB = ((N - LO) < 32) ? (N - LO) : 32;
    localparam logic [7:0] AI = A_IN + 8'(w);
    localparam logic [7:0] AE = A_IEN + 8'(w);
    localparam logic [7:0] AS = A_IST + 8'(w);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ien_q[LO +: WB] <= '0;
        ist_q[LO +: WB] <= '0;
      end else begin
        if (wr && addr == AE) ien_q[LO +: WB] <= wdata[WB-1:0];
        if (wr && addr == AS)
          ist_q[LO +: WB] <= (ist_q[LO +: WB] & ~wdata[WB-1:0]) | hit[LO +: WB];
        else
          ist_q[LO +: WB] <= ist_q[LO +: WB] | hit[LO +: WB];
      end
    end

    always_comb begin
      rdw[w] = '0;
      if (addr == AI) rdw[w] = 32'(seen[LO +: WB]);
      if (addr == AE) rdw[w] = 32'(ien_q[LO +: WB]);
      if (addr == AS) rdw[w] = 32'(ist_q[LO +: WB]);
    end

    // R10: status bits only fall through a clear write
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == AS) |=> ((ist_q[LO +: WB] & $past(ist_q[LO +: WB])) == $past(ist_q[LO +: WB])));
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NW; w++) rdata = rdata | rdw[w];
  end

  assign irq = |(ist_q & ien_q);

  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ien_q));
  a_r9_masked_input: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q & ~$past(inen)) == '0);
endmodule

// File: rtl/keyed_gpio.sv
module keyed_gpio import gpk_pkg::*; #(
  parameter int N = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  input  logic           bus_wr,
  input  logic           bus_rd,
  output logic [31:0]    bus_rdata,
  input  logic [N-1:0]   pad_in,
  output logic [N-1:0]   pad_out,
  output logic [N-1:0]   pad_oe,
  output logic [N-1:0]   pad_pull,
  output logic [N-1:0]   pad_strong,
  output logic [3*N-1:0] pad_func,
  output logic           irq
);
  pad_cfg_t     pcfg [N];
  aux_cfg_t     xcfg [N];
  logic [N-1:0] dat_q, oen_q, inen, fall;
  logic [31:0]  rd_cfg, rd_dat, rd_oen, rd_in;

  gpk_cfg_bank #(.N(N)) i_cfg (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
    .pcfg(pcfg), .xcfg(xcfg), .rdata(rd_cfg)
  );

  gpk_setclr_reg #(.N(N), .A_BASE(A_DAT), .A_SET(A_DSET), .A_CLR(A_DCLR)) i_dat (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
    .q(dat_q), .rdata(rd_dat)
  );

  gpk_setclr_reg #(.N(N), .A_BASE(A_OEN), .A_SET(A_OSET), .A_CLR(A_OCLR)) i_oen (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
    .q(oen_q), .rdata(rd_oen)
  );

  gpk_in_sense #(.N(N)) i_sense (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
    .pin(pad_in), .inen(inen), .fall(fall), .rdata(rd_in), .irq(irq)
  );

  for (genvar p = 0; p < N; p++) begin : g_pad
    logic gp;
    assign gp = (pcfg[p].func == FN_GPIO);
    assign inen[p]           = pcfg[p].inen;
    assign fall[p]           = xcfg[p].fall;
    assign pad_pull[p]       = pcfg[p].pull;
    assign pad_strong[p]     = pcfg[p].drive;
    assign pad_func[3*p +: 3] = pcfg[p].func;

    always_comb begin
      pad_oe[p]  = 1'b0;
      pad_out[p] = 1'b0;
      if (gp) begin
        unique case (xcfg[p].mode)
          OM_PUSH:  begin pad_oe[p] = 1'b1;      pad_out[p] = dat_q[p]; end
          OM_DRAIN: begin pad_oe[p] = ~dat_q[p]; pad_out[p] = 1'b0;     end
          OM_TRI:   begin pad_oe[p] = oen_q[p];  pad_out[p] = dat_q[p]; end
          default:  begin pad_oe[p] = 1'b0;      pad_out[p] = 1'b0;     end
        endcase
      end
    end

    a_r6_drain_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      (xcfg[p].mode == OM_DRAIN) |-> !(pad_oe[p] && pad_out[p]));
    a_r5_other_func_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pcfg[p].func != FN_GPIO) |-> !(pad_oe[p] || pad_out[p]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_cfg | rd_dat | rd_oen | rd_in;
  end

  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_keyed_gpio.sv
module test_keyed_gpio;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 36;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [31:0]    bus_rdata;
  logic [NP-1:0]  pad_in = '0;
  logic [NP-1:0]  pad_out, pad_oe, pad_pull, pad_strong;
  logic [3*NP-1:0] pad_func;
  logic           irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keyed_gpio #(.N(NP)) i_keyed_gpio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .pad_strong(pad_strong), .pad_func(pad_func), .irq(irq)
  );

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_pads(input logic [7:0] b);
    for (int w = 0; w < 9; w++) wr(8'h10 + 8'(w), {4{b}});
  endtask

  task automatic set_aux(input logic [31:0] v);
    for (int w = 0; w < 5; w++) wr(8'h20 + 8'(w), v);
  endtask

  task automatic wr36(input logic [7:0] a, input logic [35:0] v);
    wr(a, v[31:0]);
    wr(a + 8'd1, {28'h0, v[35:32]});
  endtask

  function automatic logic [35:0] nxt();
    logic [35:0] r;
    seed = seed * 32'd1103515245 + 32'd12345;
    r[35:32] = seed[19:16];
    seed = seed * 32'd1103515245 + 32'd12345;
    r[31:0] = seed;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [35:0] dv, ev, eo, eq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk("R12 pad_oe", pad_oe, '0);
    chk("R12 pad_out", pad_out, '0);
    chk("R12 irq", irq, 1'b0);
    rd(8'h00, d); chk("R12 key locked", d, 32'h0);
    rd(8'h34, d); chk("R12 data zero", d, 32'h0);
    rd(8'h54, d); chk("R12 status zero", d, 32'h0);

    // R2: locked writes ignored
    wr(8'h10, 32'h1B1B_1B1B); rd(8'h10, d); chk("R2 pad locked", d, 32'h0);
    wr(8'h20, 32'h5555_5555); rd(8'h20, d); chk("R2 aux locked", d, 32'h0);

    // R1: key decode
    wr(8'h00, 32'h72); rd(8'h00, d); chk("R1 wrong key", d, 32'h0);
    wr(8'h00, 32'h173); rd(8'h00, d); chk("R1 upper bits key", d, 32'h0);
    wr(8'h00, 32'h73); rd(8'h00, d); chk("R1 unlock", d, 32'h1);

    // R3: byte field readback sweep over all 256 values
    for (int k = 0; k < 64; k++) begin
      logic [7:0] b0;
      b0 = 8'(4 * k);
      wr(8'h10, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0});
      rd(8'h10, d);
      chk("R3 byte sweep", d, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0} & 32'h3F3F_3F3F);
    end
    set_pads(8'h1D);
    @(negedge clk);
    chk("R3 pull", pad_pull, {NP{1'b1}});
    chk("R3 strong", pad_strong, {NP{1'b1}});
    chk("R3 func", pad_func, {NP{3'd3}});
    set_pads(8'h10);
    @(negedge clk);
    chk("R3 pull off", pad_pull, '0);
    chk("R3 func 2", pad_func, {NP{3'd2}});

    // R4: nibble layout and tail masking
    set_aux(32'hFFFF_FFFF);
    rd(8'h20, d); chk("R4 aux word0", d, 32'h7777_7777);
    rd(8'h24, d); chk("R4 aux tail", d, 32'h0000_7777);

    // R1/R2: relock then write
    wr(8'h00, 32'h0); rd(8'h00, d); chk("R1 relock", d, 32'h0);
    set_aux(32'h0); rd(8'h20, d); chk("R2 aux held", d, 32'h7777_7777);
    wr(8'h00, 32'h73);

    // R5: non-GPIO function keeps the pin quiet (pads func 2, push-pull, data ones)
    set_aux(32'h1111_1111);
    wr36(8'h34, '1);
    wr36(8'h40, '1);
    @(negedge clk);
    chk("R5 oe quiet", pad_oe, '0);
    chk("R5 out quiet", pad_out, '0);

    // R6: every mode on all pins with several data/enable patterns
    set_pads(8'h1A);
    for (int m = 0; m < 4; m++) begin
      set_aux({8{4'(m)}});
      for (int k = 0; k < 6; k++) begin
        dv = nxt(); ev = nxt();
        wr36(8'h34, dv);
        wr36(8'h40, ev);
        @(negedge clk);
        case (m)
          0: begin eo = '0; eq = '0; end
          1: begin eo = '1; eq = dv; end
          2: begin eo = ~dv; eq = '0; end
          default: begin eo = ev; eq = dv; end
        endcase
        chk($sformatf("R6 oe mode %0d", m), pad_oe, eo);
        chk($sformatf("R6 out mode %0d", m), pad_out, eq);
      end
    end

    // R7: data plain/set/clear
    wr36(8'h34, '0);
    wr(8'h38, 32'h0000_00F0); rd(8'h34, d); chk("R7 set", d, 32'h0000_00F0);
    wr(8'h3C, 32'h0000_0030); rd(8'h34, d); chk("R7 clear", d, 32'h0000_00C0);
    wr(8'h39, 32'hFFFF_FFFF); rd(8'h35, d); chk("R7 tail mask", d, 32'h0000_000F);
    wr(8'h3D, 32'h0000_0005); rd(8'h35, d); chk("R7 tail clear", d, 32'h0000_000A);
    // R8: enable plain/set/clear
    wr36(8'h40, '0);
    wr(8'h44, 32'h8000_0001); rd(8'h40, d); chk("R8 set", d, 32'h8000_0001);
    wr(8'h48, 32'h0000_0001); rd(8'h40, d); chk("R8 clear", d, 32'h8000_0000);
    wr(8'h41, 32'h1234_5679); rd(8'h41, d); chk("R8 plain tail", d, 32'h0000_0009);
    set_aux(32'h3333_3333);
    @(negedge clk);
    chk("R8 drives tri-state oe", pad_oe, {4'h9, 32'h8000_0000});

    // R9: input masking, even pins enabled
    set_pads(8'h1A);
    for (int w = 0; w < 9; w++) wr(8'h10 + 8'(w), 32'h181A_181A);
    for (int k = 0; k < 5; k++) begin
      dv = nxt();
      pad_in = dv;
      repeat (3) @(negedge clk);
      rd(8'h30, d); chk("R9 in word0", d, dv[31:0] & 32'h5555_5555);
      rd(8'h31, d); chk("R9 in word1", d, {28'h0, dv[35:32] & 4'h5});
    end

    // R10/R11: even pins rising, odd pins falling
    set_pads(8'h1A);
    set_aux(32'h4040_4040);
    pad_in = '0;
    repeat (4) @(negedge clk);
    wr(8'h54, 32'hFFFF_FFFF); wr(8'h55, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h51, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R11 no status no irq", irq, 1'b0);
    pad_in = '1;
    repeat (4) @(negedge clk);
    rd(8'h54, d); chk("R10 rise word0", d, 32'h5555_5555);
    rd(8'h55, d); chk("R10 rise word1", d, 32'h0000_0005);
    chk("R11 irq on", irq, 1'b1);
    wr(8'h54, 32'h0000_0005);
    rd(8'h54, d); chk("R10 partial clear", d, 32'h5555_5550);
    wr(8'h54, 32'hFFFF_FFFF); wr(8'h55, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R11 cleared irq", irq, 1'b0);
    pad_in = '0;
    repeat (4) @(negedge clk);
    rd(8'h54, d); chk("R10 fall word0", d, 32'hAAAA_AAAA);
    rd(8'h55, d); chk("R10 fall word1", d, 32'h0000_000A);
    wr(8'h50, 32'h0); wr(8'h51, 32'h0);
    @(negedge clk);
    chk("R11 masked irq", irq, 1'b0);
    rd(8'h54, d); chk("R10 sticky under mask", d, 32'hAAAA_AAAA);
    wr(8'h51, 32'h0000_0008);
    @(negedge clk);
    chk("R11 pin35 enabled", irq, 1'b1);
    wr(8'h51, 32'h0000_0001);
    @(negedge clk);
    chk("R11 pin32 enabled only", irq, 1'b0);

    // R13: read data holds without a strobe
    rd(8'h00, d);
    bus_addr = 8'h54;
    repeat (3) @(negedge clk);
    chk("R13 hold", bus_rdata, 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule